// File: doc/BRIEF.md
# USB Device Frame and Bus-Event Interrupt Tracker

This block follows the frame timing of a USB device link and turns decoded bus events into sticky interrupt status. It takes start-of-frame tokens, each carrying an 11-bit frame number, and keeps the current frame number together with a 3-bit microframe number. In high-speed mode, a token that opens a new 1 ms frame raises a different status bit from a token that only steps the 125 us microframe. The two bits are never raised by the same event. After the first token has been seen, the block produces frame and microframe ticks itself from a 1 MHz tick enable whenever tokens stop arriving. Each received token reloads that timer.

The block also detects suspend, meaning the line has sat idle in the J state for three full frames. It latches one-cycle indications for the end of a bus reset, the end of a resume, a wakeup and the end of an upstream resume. Software writes an enable mask and a write-one-to-clear mask. A single interrupt line is the OR of all enabled status bits.

Top module: `usb_frame_irq_tracker`

## Requirements
- R1: After reset, status, enable, frame number and microframe number are all zero and irq is low.
- R2: Status bit 0 (speed) equals the hs_mode input sampled at the previous clock edge. A clear write to bit 0 has no effect on it.
- R3: In high-speed mode, after the first token, a token whose frame number equals the current frame number sets status bit 2 (microframe SOF) but not bit 3. It also increments the microframe number (wrapping 7 to 0) and leaves the frame number unchanged.
- R4: A token sets status bit 3 (frame SOF) but not bit 2 when it carries a different frame number, is the first token since reset, or arrives in full-speed mode. It loads the frame number from the token and sets the microframe number to 0.
- R5: Once armed, with tick_1us high and no token, a synthesized event occurs every 125 ticks in high-speed mode and every 1000 ticks in full-speed mode. In high-speed mode it acts as a microframe step (bit 2) unless the microframe number is 7, in which case it acts as a new frame. A new frame increments the frame number, clears the microframe number and sets bit 3. In full-speed mode every synthesized event is a new frame.
- R6: A synthesized new frame at frame number 2047 gives frame number 0.
- R7: Every received token restarts the synthesis timer, so the next synthesized event comes a full period after the last token.
- R8: Bit 1 (suspend) is set after 3000 consecutive ticks with bus_idle high and no token. It is set only once per idle period. Any cycle with bus_idle low restarts the count.
- R9: A one-cycle pulse on bus_reset_end, wakeup, resume_end or upstream_resume_end sets status bit 4, 5, 6 or 7 respectively.
- R10: With clr_we high, each 1 in clr_data clears the matching status bit (bits 1 to 7). A hardware set in the same cycle wins over the clear.
- R11: irq is high exactly when some status bit and the matching enable bit (loaded from en_data when en_we is high) are both 1.
- R12: Before the first token since reset, no synthesized event occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1us | input | 1 | 1 MHz timebase enable |
| hs_mode | input | 1 | Link runs in high-speed mode |
| sof_valid | input | 1 | Start-of-frame token received this cycle |
| sof_frame | input | 11 | Frame number carried by the token |
| bus_idle | input | 1 | Line idle in J state |
| bus_reset_end | input | 1 | End of bus reset pulse |
| resume_end | input | 1 | End of resume pulse |
| wakeup | input | 1 | Wakeup pulse |
| upstream_resume_end | input | 1 | End of upstream resume pulse |
| clr_we | input | 1 | Write strobe for the clear mask |
| clr_data | input | 8 | Clear mask, one bit per status bit |
| en_we | input | 1 | Write strobe for the enable mask |
| en_data | input | 8 | New enable mask |
| status | output | 8 | Sticky status bits |
| enable | output | 8 | Current enable mask |
| irq | output | 1 | Combined interrupt |
| frame_num | output | 11 | Current frame number |
| uframe_num | output | 3 | Current microframe number |

## Verification
The assertions check the following on every cycle: the two SOF status bits never rise from the same event, a microframe step leaves the frame number alone and adds one to the microframe, a new frame zeroes the microframe, a synthesized frame adds one to the frame number, the speed bit tracks hs_mode, a set beats a clear, and suspend fires at most once in a row. Only the bench scenarios can show the absolute timing: the 125, 1000 and 3000 tick windows, the timer restart after a token, and the silence before the first token. The same holds for the wrap from 2047, the restart of the idle count, and the irq masking against software-written enables.

// File: rtl/ufit_pkg.sv
package ufit_pkg;

    localparam int FRAME_W = 11;
    localparam int NUM_ST  = 8;

    typedef enum int unsigned {
        ST_SPEED      = 0,
        ST_SUSPEND    = 1,
        ST_USOF       = 2,
        ST_FSOF       = 3,
        ST_BUSRST_END = 4,
        ST_WAKE       = 5,
        ST_RESUME_END = 6,
        ST_UPRESUME   = 7
    } ufit_stat_e;

    typedef struct packed {
        logic suspend;
        logic usof;
        logic fsof;
        logic busrst_end;
        logic wake;
        logic resume_end;
        logic upresume;
    } ufit_evt_t;

    function automatic logic [NUM_ST-1:0] evt_to_vec(input ufit_evt_t e);
        logic [NUM_ST-1:0] v;
        v                = '0;
        v[ST_SUSPEND]    = e.suspend;
        v[ST_USOF]       = e.usof;
        v[ST_FSOF]       = e.fsof;
        v[ST_BUSRST_END] = e.busrst_end;
        v[ST_WAKE]       = e.wake;
        v[ST_RESUME_END] = e.resume_end;
        v[ST_UPRESUME]   = e.upresume;
        return v;
    endfunction

endpackage

// File: rtl/ufit_frame_timer.sv
module ufit_frame_timer
    import ufit_pkg::*;
#(
    parameter int TICKS_UFRAME = 125,
    parameter int UFRAMES      = 8      // power of two
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       tick,
    input  logic                       hs,
    input  logic                       sof_valid,
    input  logic [FRAME_W-1:0]         sof_frame,
    output logic [FRAME_W-1:0]         frame_num,
    output logic [$clog2(UFRAMES)-1:0] uframe_num,
    output logic                       int_evt,
    output logic                       micro_evt
);
    localparam int FS_TICKS = TICKS_UFRAME * UFRAMES;
    localparam int CNT_W    = $clog2(FS_TICKS);
    localparam int UF_W     = $clog2(UFRAMES);

    logic [CNT_W-1:0]   cnt_q;
    logic               armed_q;
    logic [FRAME_W-1:0] frame_q;
    logic [UF_W-1:0]    uf_q;

    logic [CNT_W-1:0] period_last;
    logic             last_uf;
    logic             tok_new;
    logic             synth;

    always_comb begin
        period_last = hs ? CNT_W'(TICKS_UFRAME - 1) : CNT_W'(FS_TICKS - 1);
        last_uf     = (uf_q == UF_W'(UFRAMES - 1));
        tok_new     = !armed_q || !hs || (sof_frame != frame_q);
        synth       = armed_q && tick && !sof_valid && (cnt_q >= period_last);
        if (sof_valid) begin
            int_evt   = tok_new;
            micro_evt = !tok_new;
        end else begin
            int_evt   = synth && (!hs || last_uf);
            micro_evt = synth && hs && !last_uf;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
            frame_q <= '0;
            uf_q    <= '0;
        end else if (sof_valid) begin
            armed_q <= 1'b1;
            cnt_q   <= '0;
            if (tok_new) begin
                frame_q <= sof_frame;
                uf_q    <= '0;
            end else begin
                uf_q <= uf_q + 1'b1;
            end
        end else if (armed_q && tick) begin
            cnt_q <= synth ? '0 : cnt_q + 1'b1;
            if (int_evt) begin
                frame_q <= frame_q + 1'b1;
                uf_q    <= '0;
            end else if (micro_evt) begin
                uf_q <= uf_q + 1'b1;
            end
        end
    end

    assign frame_num  = frame_q;
    assign uframe_num = uf_q;

    a_r4_sof_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(int_evt && micro_evt));

    a_r3_micro_holds_frame: assert property (@(posedge clk) disable iff (rst)
        micro_evt |=> ($stable(frame_num) && uframe_num == $past(uframe_num) + 1'b1));

    a_r4_frame_start_zero: assert property (@(posedge clk) disable iff (rst)
        int_evt |=> (uframe_num == '0));

    a_r5_synth_frame_step: assert property (@(posedge clk) disable iff (rst)
        (int_evt && !sof_valid) |=> (frame_num == $past(frame_num) + 1'b1));

endmodule

// File: rtl/ufit_suspend_det.sv
module ufit_suspend_det #(
    parameter int IDLE_TICKS = 3000
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic idle,
    input  logic activity,
    output logic evt
);
    localparam int CW = $clog2(IDLE_TICKS + 1);

    logic [CW-1:0] cnt_q;
    logic          done_q;

    assign evt = tick && idle && !activity && !done_q && (cnt_q == CW'(IDLE_TICKS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (!idle || activity) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (tick && !done_q) begin
            if (evt) begin
                cnt_q  <= '0;
                done_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    a_r8_needs_idle: assert property (@(posedge clk) disable iff (rst)
        evt |-> $past(idle));

    a_r8_once_per_idle: assert property (@(posedge clk) disable iff (rst)
        evt |=> !evt);

endmodule

// File: rtl/ufit_status_regs.sv
module ufit_status_regs
    import ufit_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hs,
    input  ufit_evt_t         evt,
    input  logic              clr_we,
    input  logic [NUM_ST-1:0] clr_data,
    input  logic              en_we,
    input  logic [NUM_ST-1:0] en_data,
    output logic [NUM_ST-1:0] status,
    output logic [NUM_ST-1:0] enable,
    output logic              irq
);
    logic [NUM_ST-1:0] status_q;
    logic [NUM_ST-1:0] enable_q;
    logic [NUM_ST-1:0] set_vec;
    logic [NUM_ST-1:0] clr_vec;
    logic [NUM_ST-1:0] status_d;

    always_comb begin
        set_vec = evt_to_vec(evt);
        clr_vec = clr_we ? clr_data : '0;
        for (int i = 0; i < NUM_ST; i++) begin
            status_d[i] = (status_q[i] & ~clr_vec[i]) | set_vec[i];
        end
        status_d[ST_SPEED] = hs;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            enable_q <= '0;
        end else begin
            status_q <= status_d;
            if (en_we) enable_q <= en_data;
        end
    end

    assign status = status_q;
    assign enable = enable_q;
    assign irq    = |(status_q & enable_q);

    a_r2_speed_follows: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (status[ST_SPEED] == $past(hs)));

    a_r10_set_wins: assert property (@(posedge clk) disable iff (rst)
        (|set_vec) |=> ((status & $past(set_vec)) == $past(set_vec)));

    for (genvar g = 1; g < NUM_ST; g++) begin : g_clr_chk
        a_r10_clear_bit: assert property (@(posedge clk) disable iff (rst)
            (clr_vec[g] && !set_vec[g]) |=> !status[g]);
    end

endmodule

// File: rtl/usb_frame_irq_tracker.sv
module usb_frame_irq_tracker
    import ufit_pkg::*;
#(
    parameter int TICKS_UFRAME = 125,
    parameter int UFRAMES      = 8,
    parameter int SUSP_FRAMES  = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       tick_1us,
    input  logic                       hs_mode,
    input  logic                       sof_valid,
    input  logic [10:0]                sof_frame,
    input  logic                       bus_idle,
    input  logic                       bus_reset_end,
    input  logic                       resume_end,
    input  logic                       wakeup,
    input  logic                       upstream_resume_end,
    input  logic                       clr_we,
    input  logic [7:0]                 clr_data,
    input  logic                       en_we,
    input  logic [7:0]                 en_data,
    output logic [7:0]                 status,
    output logic [7:0]                 enable,
    output logic                       irq,
    output logic [10:0]                frame_num,
    output logic [$clog2(UFRAMES)-1:0] uframe_num
);
    localparam int IDLE_TICKS = SUSP_FRAMES * TICKS_UFRAME * UFRAMES;

    logic      int_evt;
    logic      micro_evt;
    logic      susp_evt;
    ufit_evt_t evt;

    ufit_frame_timer #(
        .TICKS_UFRAME (TICKS_UFRAME),
        .UFRAMES      (UFRAMES)
    ) u_timer (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick_1us),
        .hs         (hs_mode),
        .sof_valid  (sof_valid),
        .sof_frame  (sof_frame),
        .frame_num  (frame_num),
        .uframe_num (uframe_num),
        .int_evt    (int_evt),
        .micro_evt  (micro_evt)
    );

    ufit_suspend_det #(
        .IDLE_TICKS (IDLE_TICKS)
    ) u_susp (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick_1us),
        .idle     (bus_idle),
        .activity (sof_valid),
        .evt      (susp_evt)
    );

    always_comb begin
        evt.suspend    = susp_evt;
        evt.usof       = micro_evt;
        evt.fsof       = int_evt;
        evt.busrst_end = bus_reset_end;
        evt.wake       = wakeup;
        evt.resume_end = resume_end;
        evt.upresume   = upstream_resume_end;
    end

    ufit_status_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .hs       (hs_mode),
        .evt      (evt),
        .clr_we   (clr_we),
        .clr_data (clr_data),
        .en_we    (en_we),
        .en_data  (en_data),
        .status   (status),
        .enable   (enable),
        .irq      (irq)
    );

    a_r11_irq_masked: assert property (@(posedge clk) disable iff (rst)
        (enable == 8'h00) |-> !irq);

endmodule

// File: tb/usb_frame_irq_tracker_test.sv
module usb_frame_irq_tracker_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        tick_1us, hs_mode, sof_valid, bus_idle;
    logic [10:0] sof_frame;
    logic        bus_reset_end, resume_end, wakeup, upstream_resume_end;
    logic        clr_we, en_we;
    logic [7:0]  clr_data, en_data;
    logic [7:0]  status, enable;
    logic        irq;
    logic [10:0] frame_num;
    logic [2:0]  uframe_num;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    bit          armed = 1'b0;
    logic [10:0] ef = '0;
    logic [2:0]  eu = '0;

    always #2 clk = ~clk;

    usb_frame_irq_tracker uut (
        .clk(clk), .rst(rst), .tick_1us(tick_1us), .hs_mode(hs_mode),
        .sof_valid(sof_valid), .sof_frame(sof_frame), .bus_idle(bus_idle),
        .bus_reset_end(bus_reset_end), .resume_end(resume_end), .wakeup(wakeup),
        .upstream_resume_end(upstream_resume_end), .clr_we(clr_we), .clr_data(clr_data),
        .en_we(en_we), .en_data(en_data), .status(status), .enable(enable), .irq(irq),
        .frame_num(frame_num), .uframe_num(uframe_num)
    );

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    function automatic logic [1:0] exp_sof_bits(input bit arm, input logic hs,
                                                input logic [10:0] f, input logic [10:0] cur);
        if (!arm || !hs || f != cur) return 2'b10;
        return 2'b01;
    endfunction

    task automatic clr_all();
        clr_we = 1'b1; clr_data = 8'hFF;
        cyc();
        clr_we = 1'b0; clr_data = 8'h00;
    endtask

    // token with an all-ones clear in the same cycle: only the new SOF bit stays
    task automatic send_tok(input logic [10:0] f, input string tag);
        logic [1:0] eb;
        eb = exp_sof_bits(armed, hs_mode, f, ef);
        if (eb == 2'b10) begin ef = f; eu = 3'd0; end
        else eu = eu + 3'd1;
        armed = 1'b1;
        sof_valid = 1'b1; sof_frame = f; clr_we = 1'b1; clr_data = 8'hFF;
        cyc();
        sof_valid = 1'b0; clr_we = 1'b0; clr_data = 8'h00;
        chk({tag, " frame"}, frame_num, ef);
        chk({tag, " uframe"}, uframe_num, eu);
        chk({tag, " sof bits"}, status[3:2], eb);
    endtask

    initial begin
        void'($urandom(32'd20240));
        rst = 1'b1; tick_1us = 1'b1; hs_mode = 1'b1; sof_valid = 1'b0; sof_frame = '0;
        bus_idle = 1'b0; bus_reset_end = 1'b0; resume_end = 1'b0; wakeup = 1'b0;
        upstream_resume_end = 1'b0; clr_we = 1'b0; en_we = 1'b0;
        clr_data = 8'h00; en_data = 8'h00;
        repeat (3) cyc();
        // R1: reset state
        chk("R1 status", status, 0);
        chk("R1 enable", enable, 0);
        chk("R1 frame", frame_num, 0);
        chk("R1 uframe", uframe_num, 0);
        chk("R1 irq", irq, 0);
        rst = 1'b0;
        cyc();
        // R2: speed bit follows hs_mode, cannot be cleared
        chk("R2 speed hs", status[0], 1);
        clr_we = 1'b1; clr_data = 8'h01;
        cyc();
        clr_we = 1'b0; clr_data = 8'h00;
        chk("R2 speed clear ignored", status[0], 1);

        // R12: no synthesized events before the first token
        repeat (1100) cyc();
        chk("R12 no sof before token", status[3:2], 0);
        chk("R12 frame unchanged", frame_num, 0);

        // R3 / R4 / R10: random high-speed tokens (set wins over same-cycle clear)
        for (int i = 0; i < 150; i++) begin
            logic [10:0] f;
            if (armed && ($urandom % 2 == 0)) f = ef;
            else f = ef + 11'(1 + $urandom % 2046);
            send_tok(f, "R3/R4/R10 random token");
            repeat ($urandom % 3) cyc();
        end

        // R5 / R6: synthesized microframes from frame 2047 across the wrap
        if (ef == 11'd2047) send_tok(11'd5, "R4 pre-wrap token");
        send_tok(11'd2047, "R4 token 2047");
        for (int k = 1; k <= 8; k++) begin
            clr_all();
            repeat (123) cyc();
            chk("R5 no synth early", status[3:2], 0);
            cyc();
            if (k < 8) begin
                chk("R5 synth micro bits", status[3:2], 2'b01);
                chk("R5 synth uframe", uframe_num, k);
                chk("R5 synth frame held", frame_num, 2047);
            end else begin
                chk("R6 synth new frame bits", status[3:2], 2'b10);
                chk("R6 frame wrap", frame_num, 0);
                chk("R6 uframe zero", uframe_num, 0);
            end
        end
        ef = 11'd0; eu = 3'd0;

        // R7: a token restarts the synthesis timer
        repeat (60) cyc();
        send_tok(11'd0, "R7 mid-period token");
        clr_all();
        repeat (123) cyc();
        chk("R7 no synth after reload", status[3:2], 0);
        cyc();
        chk("R7 synth one period later", status[3:2], 2'b01);
        chk("R7 uframe", uframe_num, 2);

        // full-speed mode
        hs_mode = 1'b0;
        cyc();
        chk("R2 speed fs", status[0], 0);
        send_tok(11'd100, "R4 fs token");
        send_tok(11'd100, "R4 fs same-number token");
        clr_all();
        repeat (998) cyc();
        chk("R5 fs no synth early", status[3:2], 0);
        cyc();
        chk("R5 fs synth bits", status[3:2], 2'b10);
        chk("R5 fs synth frame", frame_num, 101);
        chk("R5 fs uframe", uframe_num, 0);

        // R8: suspend detection
        bus_idle = 1'b1;
        clr_all();
        repeat (2998) cyc();
        chk("R8 no suspend early", status[1], 0);
        cyc();
        chk("R8 suspend set", status[1], 1);
        clr_all();
        repeat (4000) cyc();
        chk("R8 once per idle period", status[1], 0);
        bus_idle = 1'b0;
        cyc();
        bus_idle = 1'b1;
        repeat (1500) cyc();
        bus_idle = 1'b0;
        cyc();
        bus_idle = 1'b1;
        repeat (2999) cyc();
        chk("R8 count restarted", status[1], 0);
        cyc();
        chk("R8 suspend after restart", status[1], 1);
        bus_idle = 1'b0;
        clr_all();

        // R9: event pulses
        bus_reset_end = 1'b1; cyc(); bus_reset_end = 1'b0;
        chk("R9 bus reset end", status[4], 1);
        wakeup = 1'b1; cyc(); wakeup = 1'b0;
        chk("R9 wakeup", status[5], 1);
        resume_end = 1'b1; cyc(); resume_end = 1'b0;
        chk("R9 resume end", status[6], 1);
        upstream_resume_end = 1'b1; cyc(); upstream_resume_end = 1'b0;
        chk("R9 upstream resume end", status[7], 1);

        // R10: clear, and set beats clear
        clr_we = 1'b1; clr_data = 8'h50; cyc(); clr_we = 1'b0; clr_data = 8'h00;
        chk("R10 clear bits 4,6", status[7:4], 4'b1010);
        wakeup = 1'b1; clr_we = 1'b1; clr_data = 8'h20;
        cyc();
        wakeup = 1'b0; clr_we = 1'b0; clr_data = 8'h00;
        chk("R10 set wins", status[5], 1);

        // R11: interrupt masking
        clr_all();
        wakeup = 1'b1; cyc(); wakeup = 1'b0;
        chk("R11 irq disabled", irq, 0);
        en_we = 1'b1; en_data = 8'h80; cyc(); en_we = 1'b0;
        chk("R11 enable readback", enable, 8'h80);
        chk("R11 irq other bit enabled", irq, 0);
        en_we = 1'b1; en_data = 8'h20; cyc(); en_we = 1'b0;
        chk("R11 irq enabled", irq, 1);
        clr_we = 1'b1; clr_data = 8'h20; cyc(); clr_we = 1'b0; clr_data = 8'h00;
        chk("R11 irq after clear", irq, 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule